// File: doc/BRIEF.md
# Immediate-Offset Load Unit

This unit executes a single 32-bit load instruction word that uses an immediate addressing form. It supports three forms. Post-indexed loads access memory at the base and then write back base plus a signed 9-bit offset. Pre-indexed loads add the signed offset first, then both access and write back at the sum. Unsigned-offset loads add a zero-extended 12-bit offset, scaled by the access size, and do not write back. The base comes from a combinational register-file read port, or from a separate stack-pointer input when the base index is 31.

Once an instruction is accepted through a valid/ready handshake, the unit decodes the word and checks alignment if the stack pointer is the base. It then issues one memory read with a valid/ready request and a valid-only response, and finishes with a one-cycle done pulse. In that done cycle the destination write and any base writeback are presented together on separate ports. A writeback to index 31 goes out on the stack-pointer port instead of the register port. Illegal encodings and misaligned stack-pointer bases end with a one-cycle flag, with no memory traffic and no writes.

Top module: `ldimm_unit`

## Requirements
- R1: A word is legal only if bit 31 = 1, bits 29:27 = 111, bit 26 = 0, bits 23:22 = 01, and either bits 25:24 = 01, or bits 25:24 = 00 with bit 21 = 0 and bits 11:10 equal to 01 or 11. Any other word raises `undef_o` for exactly one cycle, with no memory request and no write strobe.
- R2: Post-indexed form (bits 25:24 = 00, bit 21 = 0, bits 11:10 = 01): the request address is the unmodified base. Base plus the sign-extended offset in bits 20:12 is written back to the base register.
- R3: Pre-indexed form (bits 11:10 = 11, otherwise as R2): the request address is base plus the sign-extended bits 20:12, and that same sum is written back.
- R4: Unsigned-offset form (bits 25:24 = 01): the request address is base plus bits 21:10 zero-extended and shifted left by 2 (bit 30 = 0) or by 3 (bit 30 = 1). No writeback strobe is raised.
- R5: Bit 30 selects the access size. With 0, the request byte count is 4 and the destination receives the low 32 response bits with the upper 32 bits zero. With 1, the count is 8 and all 64 bits are written. The destination index is bits 4:0.
- R6: A base index (bits 9:5) of 31 takes the base from `sp_in`. A writeback for that base is presented on `sp_we`/`sp_data` and never on the register writeback port.
- R7: With base index 31 and any of `sp_in[3:0]` nonzero, `align_fault_o` is raised for one cycle, and no memory request, destination write or writeback follows.
- R8: For a writeback form where base index equals destination index and the index is not 31, the writeback is suppressed and only the loaded value is written.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid with its address and byte count unchanged.
- R10: The destination write, any writeback and `done_o` are all high in the same single cycle, and all are low the cycle after.
- R11: `insn_ready` is high only while idle, so a word offered while busy is not taken. Reset returns the unit to idle with every request, write and flag output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction word offered |
| insn_ready | output | 1 | Unit idle and able to take a word |
| insn | input | 32 | Instruction word |
| rf_rd_idx | output | 5 | Register-file read index for the base |
| rf_rd_data | input | 64 | Register-file read data (combinational) |
| sp_in | input | 64 | Current stack-pointer value |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Request byte address |
| mem_req_bytes | output | 4 | Request size in bytes (4 or 8) |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 64 | Read response data |
| rd_we | output | 1 | Destination register write strobe |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | 64 | Destination write data |
| wb_we | output | 1 | Base register writeback strobe |
| wb_idx | output | 5 | Base register writeback index |
| wb_data | output | 64 | Base writeback value |
| sp_we | output | 1 | Stack-pointer writeback strobe |
| sp_data | output | 64 | Stack-pointer writeback value |
| undef_o | output | 1 | Illegal encoding pulse |
| align_fault_o | output | 1 | Misaligned stack-pointer base pulse |
| done_o | output | 1 | Load completion pulse |

## Verification
The case that is hardest to reach from the ports is a writeback that collides with a destination. To get there, the word must use a writeback form with equal base and destination fields, and the base must not be 31. The bench builds such words for both sizes and both indexed forms. It also builds the neighbouring case with both fields set to 31, where the stack-pointer writeback must still happen. The request hold is exercised by delaying `mem_req_ready` for up to three cycles. Acceptance while busy is tested by keeping `insn_valid` high with an illegal word for the whole load. That word must not disturb the result or raise the undefined flag.

// File: rtl/ldimm_pkg.sv
package ldimm_pkg;
    localparam int XLEN         = 64;
    localparam int INSN_W       = 32;
    localparam int IDX_W        = 5;
    localparam int IMM9_W       = 9;
    localparam int IMM12_W      = 12;
    localparam int BYTES_W      = 4;
    localparam int SP_ALIGN_LSB = 4;
    localparam int WORD_W       = 32;
    localparam logic [IDX_W-1:0] SP_IDX = '1;

    typedef enum logic [1:0] {
        AM_POST = 2'd0,
        AM_PRE  = 2'd1,
        AM_UOFF = 2'd2,
        AM_NONE = 2'd3
    } amode_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_EXEC = 3'd1,
        ST_REQ  = 3'd2,
        ST_RSP  = 3'd3,
        ST_DONE = 3'd4
    } state_e;

    typedef struct packed {
        logic              legal;
        amode_e            mode;
        logic              dword;
        logic              wback;
        logic [IDX_W-1:0]  rn;
        logic [IDX_W-1:0]  rt;
        logic [XLEN-1:0]   offset;
    } dec_t;

    function automatic logic [XLEN-1:0] sext_imm9(input logic [IMM9_W-1:0] v);
        return {{(XLEN-IMM9_W){v[IMM9_W-1]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] scale_imm12(input logic [IMM12_W-1:0] v,
                                                    input logic dword);
        logic [XLEN-1:0] z;
        z = {{(XLEN-IMM12_W){1'b0}}, v};
        return dword ? (z << 3) : (z << 2);
    endfunction

    function automatic logic [BYTES_W-1:0] access_bytes(input logic dword);
        return dword ? BYTES_W'(8) : BYTES_W'(4);
    endfunction

    function automatic logic [XLEN-1:0] fit_load(input logic [XLEN-1:0] raw,
                                                 input logic dword);
        return dword ? raw : {{(XLEN-WORD_W){1'b0}}, raw[WORD_W-1:0]};
    endfunction
endpackage

// File: rtl/ldimm_decode.sv
module ldimm_decode import ldimm_pkg::*; (
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);
    amode_e mode;
    logic   common_ok;
    logic   wants_wb;
    logic   overlap;

    always_comb begin
        common_ok = insn[31] && (insn[29:27] == 3'b111) && !insn[26]
                    && (insn[23:22] == 2'b01);
        mode = AM_NONE;
        if (common_ok) begin
            if (insn[25:24] == 2'b01) begin
                mode = AM_UOFF;
            end else if (insn[25:24] == 2'b00 && !insn[21]) begin
                if (insn[11:10] == 2'b01)      mode = AM_POST;
                else if (insn[11:10] == 2'b11) mode = AM_PRE;
            end
        end

        wants_wb = (mode == AM_POST) || (mode == AM_PRE);
        overlap  = wants_wb && (insn[9:5] == insn[4:0]) && (insn[9:5] != SP_IDX);

        dec.legal  = (mode != AM_NONE);
        dec.mode   = mode;
        dec.dword  = insn[30];
        dec.wback  = wants_wb && !overlap;
        dec.rn     = insn[9:5];
        dec.rt     = insn[4:0];
        dec.offset = (mode == AM_UOFF) ? scale_imm12(insn[21:10], insn[30])
                                       : sext_imm9(insn[20:12]);
    end
endmodule

// File: rtl/ldimm_agen.sv
module ldimm_agen import ldimm_pkg::*; (
    input  amode_e            mode,
    input  logic [XLEN-1:0]   offset,
    input  logic [XLEN-1:0]   base,
    output logic [XLEN-1:0]   acc_addr,
    output logic [XLEN-1:0]   wb_addr
);
    logic [XLEN-1:0] sum;

    assign sum      = base + offset;
    assign acc_addr = (mode == AM_POST) ? base : sum;
    assign wb_addr  = sum;
endmodule

// File: rtl/ldimm_ctrl.sv
module ldimm_ctrl import ldimm_pkg::*; (
    input  logic clk,
    input  logic rst,
    input  logic insn_valid,
    input  logic legal,
    input  logic misalign,
    input  logic req_ready,
    input  logic rsp_valid,
    output logic insn_ready,
    output logic accept,
    output logic exec_ok,
    output logic req_valid,
    output logic rsp_take,
    output logic undef,
    output logic fault,
    output logic done
);
    state_e st, st_nx;

    always_comb begin
        st_nx = st;
        case (st)
            ST_IDLE: if (insn_valid) st_nx = ST_EXEC;
            ST_EXEC: st_nx = (legal && !misalign) ? ST_REQ : ST_IDLE;
            ST_REQ:  if (req_ready) st_nx = ST_RSP;
            ST_RSP:  if (rsp_valid) st_nx = ST_DONE;
            ST_DONE: st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nx;
    end

    assign insn_ready = (st == ST_IDLE);
    assign accept     = insn_ready && insn_valid;
    assign exec_ok    = (st == ST_EXEC) && legal && !misalign;
    assign undef      = (st == ST_EXEC) && !legal;
    assign fault      = (st == ST_EXEC) && legal && misalign;
    assign req_valid  = (st == ST_REQ);
    assign rsp_take   = (st == ST_RSP) && rsp_valid;
    assign done       = (st == ST_DONE);

    // R1: undefined flag lasts one cycle
    p_undef_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        undef |=> !undef);

    // R9: a pending request is not withdrawn
    p_req_wait_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> req_valid);
endmodule

// File: rtl/ldimm_unit.sv
module ldimm_unit import ldimm_pkg::*; (
    input  logic                clk,
    input  logic                rst,
    input  logic                insn_valid,
    output logic                insn_ready,
    input  logic [INSN_W-1:0]   insn,
    output logic [IDX_W-1:0]    rf_rd_idx,
    input  logic [XLEN-1:0]     rf_rd_data,
    input  logic [XLEN-1:0]     sp_in,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [XLEN-1:0]     mem_req_addr,
    output logic [BYTES_W-1:0]  mem_req_bytes,
    input  logic                mem_rsp_valid,
    input  logic [XLEN-1:0]     mem_rsp_data,
    output logic                rd_we,
    output logic [IDX_W-1:0]    rd_idx,
    output logic [XLEN-1:0]     rd_data,
    output logic                wb_we,
    output logic [IDX_W-1:0]    wb_idx,
    output logic [XLEN-1:0]     wb_data,
    output logic                sp_we,
    output logic [XLEN-1:0]     sp_data,
    output logic                undef_o,
    output logic                align_fault_o,
    output logic                done_o
);
    logic [INSN_W-1:0] insn_q;
    dec_t              dec;
    logic [XLEN-1:0]   base;
    logic [XLEN-1:0]   acc_addr, wb_addr;
    logic [XLEN-1:0]   addr_q, wbv_q, data_q;
    logic              base_is_sp, misalign;
    logic              accept, exec_ok, rsp_take;

    ldimm_decode u_dec (
        .insn (insn_q),
        .dec  (dec)
    );

    assign base_is_sp = (dec.rn == SP_IDX);
    assign rf_rd_idx  = dec.rn;
    assign base       = base_is_sp ? sp_in : rf_rd_data;
    assign misalign   = base_is_sp && (|sp_in[SP_ALIGN_LSB-1:0]);

    ldimm_agen u_agen (
        .mode     (dec.mode),
        .offset   (dec.offset),
        .base     (base),
        .acc_addr (acc_addr),
        .wb_addr  (wb_addr)
    );

    ldimm_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .insn_valid (insn_valid),
        .legal      (dec.legal),
        .misalign   (misalign),
        .req_ready  (mem_req_ready),
        .rsp_valid  (mem_rsp_valid),
        .insn_ready (insn_ready),
        .accept     (accept),
        .exec_ok    (exec_ok),
        .req_valid  (mem_req_valid),
        .rsp_take   (rsp_take),
        .undef      (undef_o),
        .fault      (align_fault_o),
        .done       (done_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            insn_q <= '0;
            addr_q <= '0;
            wbv_q  <= '0;
            data_q <= '0;
        end else begin
            if (accept)   insn_q <= insn;
            if (exec_ok) begin
                addr_q <= acc_addr;
                wbv_q  <= wb_addr;
            end
            if (rsp_take) data_q <= mem_rsp_data;
        end
    end

    assign mem_req_addr  = addr_q;
    assign mem_req_bytes = access_bytes(dec.dword);

    assign rd_we   = done_o;
    assign rd_idx  = dec.rt;
    assign rd_data = fit_load(data_q, dec.dword);

    assign wb_we   = done_o && dec.wback && !base_is_sp;
    assign wb_idx  = dec.rn;
    assign wb_data = wbv_q;
    assign sp_we   = done_o && dec.wback && base_is_sp;
    assign sp_data = wbv_q;

    // R1: an illegal word produces no traffic
    p_undef_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        undef_o |-> (!mem_req_valid && !rd_we && !wb_we && !sp_we));

    // R4: unsigned-offset form never writes back
    p_uoff_no_wb_r4: assert property (@(posedge clk) disable iff (rst)
        (done_o && dec.mode == AM_UOFF) |-> (!wb_we && !sp_we));

    // R5: request size is one of the two legal counts
    p_bytes_legal_r5: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (mem_req_bytes == BYTES_W'(4) || mem_req_bytes == BYTES_W'(8)));

    // R6: only one writeback channel is used at a time
    p_one_wb_port_r6: assert property (@(posedge clk) disable iff (rst)
        !(wb_we && sp_we));

    // R7: a fault cycle is followed by no request
    p_fault_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        align_fault_o |=> (!mem_req_valid && !rd_we));

    // R8: register writeback never targets the destination register
    p_no_overlap_wb_r8: assert property (@(posedge clk) disable iff (rst)
        wb_we |-> (wb_idx != rd_idx));

    // R9: stalled request keeps address and size
    p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> ($stable(mem_req_addr) && $stable(mem_req_bytes)));

    // R10: writebacks only alongside the destination write and done
    p_wb_with_done_r10: assert property (@(posedge clk) disable iff (rst)
        (wb_we || sp_we) |-> (rd_we && done_o));

    // R10: done is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R11: no new word is taken while a request is outstanding
    p_busy_not_ready_r11: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !insn_ready);
endmodule

// File: tb/ldimm_unit_test.sv
`timescale 1ns/1ps
module ldimm_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        insn_valid = 1'b0;
    logic        insn_ready;
    logic [31:0] insn = '0;
    logic [4:0]  rf_rd_idx;
    logic [63:0] rf_rd_data;
    logic [63:0] sp_in = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic [3:0]  mem_req_bytes;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        rd_we, wb_we, sp_we;
    logic [4:0]  rd_idx, wb_idx;
    logic [63:0] rd_data, wb_data, sp_data;
    logic        undef_o, align_fault_o, done_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    function automatic logic [63:0] regval(input logic [4:0] i);
        return 64'h0000_4000_0000_0000 + ({59'd0, i} << 12) + ({59'd0, i} << 3);
    endfunction

    function automatic logic [63:0] mdata(input logic [63:0] a);
        return (a * 64'h9E37_79B9_7F4A_7C15) ^ 64'hC3A5_5A3C_0F0F_F0F0;
    endfunction

    assign rf_rd_data = regval(rf_rd_idx);

    ldimm_unit uut (
        .clk(clk), .rst(rst),
        .insn_valid(insn_valid), .insn_ready(insn_ready), .insn(insn),
        .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data), .sp_in(sp_in),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_bytes(mem_req_bytes),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rd_we(rd_we), .rd_idx(rd_idx), .rd_data(rd_data),
        .wb_we(wb_we), .wb_idx(wb_idx), .wb_data(wb_data),
        .sp_we(sp_we), .sp_data(sp_data),
        .undef_o(undef_o), .align_fault_o(align_fault_o), .done_o(done_o)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL R11 watchdog expired actual=%0d expected<=150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // observations of the last issued word
    logic        req_seen, unstable, busy_bad, saw_done, saw_undef, saw_fault;
    logic        rd_seen, rd_off_done, wb_seen, sp_seen, ready_at_issue;
    logic        post_quiet, timed_out;
    logic [63:0] a0, rdd, wbd, spd;
    logic [3:0]  b0;
    logic [4:0]  rdi, wbi;

    localparam logic [31:0] JUNK = 32'h0000_0000;

    task automatic issue(input logic [31:0] w, input int stall, input bit junk);
        bit fin;
        bit fire;
        int waited;
        req_seen = 0; unstable = 0; busy_bad = 0; saw_done = 0; saw_undef = 0;
        saw_fault = 0; rd_seen = 0; rd_off_done = 0; wb_seen = 0; sp_seen = 0;
        a0 = '0; b0 = '0; rdd = '0; wbd = '0; spd = '0; rdi = '0; wbi = '0;
        fin = 0; fire = 0; waited = 0;
        @(negedge clk);
        ready_at_issue = insn_ready;
        insn = w;
        insn_valid = 1'b1;
        @(negedge clk);
        if (junk) insn = JUNK;
        else      insn_valid = 1'b0;
        for (int i = 0; i < 80 && !fin; i++) begin
            if (undef_o)       saw_undef = 1;
            if (align_fault_o) saw_fault = 1;
            if (mem_req_valid) begin
                if (!req_seen) begin
                    req_seen = 1; a0 = mem_req_addr; b0 = mem_req_bytes;
                end else if (mem_req_addr != a0 || mem_req_bytes != b0) begin
                    unstable = 1;
                end
            end
            if (!done_o && insn_ready) busy_bad = 1;
            if (rd_we) begin
                rd_seen = 1; rdi = rd_idx; rdd = rd_data;
                if (!done_o) rd_off_done = 1;
            end
            if (wb_we) begin wb_seen = 1; wbi = wb_idx; wbd = wb_data; end
            if (sp_we) begin sp_seen = 1; spd = sp_data; end
            if (done_o) saw_done = 1;
            if (done_o || undef_o || align_fault_o) fin = 1;
            mem_req_ready = 1'b0;
            mem_rsp_valid = 1'b0;
            if (fire) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mdata(a0);
                fire = 0;
            end else if (mem_req_valid) begin
                if (waited == stall) begin
                    mem_req_ready = 1'b1;
                    fire = 1;
                end
                waited++;
            end
            if (fin) insn_valid = 1'b0;
            @(negedge clk);
        end
        timed_out  = !fin;
        post_quiet = !done_o && !undef_o && !align_fault_o && !rd_we && !wb_we && !sp_we;
        insn_valid = 1'b0;
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
    endtask

    function automatic logic [31:0] enc(input int m, input int sz, input logic [11:0] imm,
                                        input logic [4:0] rn, input logic [4:0] rt);
        logic s;
        s = (sz != 0);
        if (m == 2) return {1'b1, s, 3'b111, 1'b0, 2'b01, 2'b01, imm, rn, rt};
        return {1'b1, s, 3'b111, 1'b0, 2'b00, 2'b01, 1'b0, imm[8:0],
                (m == 1) ? 2'b11 : 2'b01, rn, rt};
    endfunction

    task automatic run_load(input int m, input int sz, input logic [11:0] imm,
                            input logic [4:0] rn, input logic [4:0] rt,
                            input logic [63:0] spv, input int stall, input bit junk);
        logic [63:0] base, off, sum, eaddr, edata;
        bit wbform, overlap, ewb, esp, efault;
        string rq;
        rq = (m == 0) ? "R2" : (m == 1) ? "R3" : "R4";
        sp_in = spv;
        base = (rn == 5'd31) ? spv : regval(rn);
        off  = (m == 2) ? ({52'd0, imm} << (2 + sz)) : {{55{imm[8]}}, imm[8:0]};
        sum  = base + off;
        eaddr = (m == 0) ? base : sum;
        edata = (sz != 0) ? mdata(eaddr) : {32'd0, mdata(eaddr)[31:0]};
        wbform  = (m != 2);
        overlap = wbform && rn == rt && rn != 5'd31;
        ewb = wbform && !overlap && rn != 5'd31;
        esp = wbform && rn == 5'd31;
        efault = (rn == 5'd31) && (spv[3:0] != 4'd0);

        issue(enc(m, sz, imm, rn, rt), stall, junk);

        chk(ready_at_issue, "R11 ready when idle", {63'd0, ready_at_issue}, 64'd1);
        chk(!timed_out, "R10 completion", {63'd0, timed_out}, 64'd0);
        chk(!saw_undef, "R1 legal word flagged", {63'd0, saw_undef}, 64'd0);
        chk(post_quiet, "R10 pulses end after one cycle", {63'd0, post_quiet}, 64'd1);
        if (efault) begin
            chk(saw_fault, "R7 fault flag", {63'd0, saw_fault}, 64'd1);
            chk(!req_seen && !rd_seen && !wb_seen && !sp_seen, "R7 no traffic after fault",
                {60'd0, req_seen, rd_seen, wb_seen, sp_seen}, 64'd0);
        end else begin
            chk(!saw_fault, "R7 spurious fault", {63'd0, saw_fault}, 64'd0);
            chk(req_seen && a0 == eaddr, (rn == 5'd31) ? "R6 sp-based address" : rq, a0, eaddr);
            chk(b0 == ((sz != 0) ? 4'd8 : 4'd4), "R5 byte count", {60'd0, b0},
                (sz != 0) ? 64'd8 : 64'd4);
            chk(!unstable, "R9 request held", {63'd0, unstable}, 64'd0);
            chk(saw_done && rd_seen && !rd_off_done, "R10 write with done",
                {61'd0, saw_done, rd_seen, rd_off_done}, 64'd6);
            chk(rdi == rt, "R5 destination index", {59'd0, rdi}, {59'd0, rt});
            chk(rdd == edata, "R5 loaded value", rdd, edata);
            chk(wb_seen == ewb, overlap ? "R8 overlap writeback" : rq,
                {63'd0, wb_seen}, {63'd0, ewb});
            if (ewb) begin
                chk(wbd == sum && wbi == rn, rq, wbd, sum);
            end
            chk(sp_seen == esp, "R6 sp writeback strobe", {63'd0, sp_seen}, {63'd0, esp});
            if (esp) chk(spd == sum, "R6 sp writeback value", spd, sum);
            chk(!busy_bad, "R11 ready while busy", {63'd0, busy_bad}, 64'd0);
        end
    endtask

    task automatic run_bad(input logic [31:0] w);
        issue(w, 0, 0);
        chk(saw_undef && !timed_out, "R1 undefined flag", {63'd0, saw_undef}, 64'd1);
        chk(!req_seen && !rd_seen && !wb_seen && !sp_seen, "R1 no traffic",
            {60'd0, req_seen, rd_seen, wb_seen, sp_seen}, 64'd0);
        chk(post_quiet, "R1 flag lasts one cycle", {63'd0, post_quiet}, 64'd1);
    endtask

    initial begin
        logic [31:0] good;
        logic [8:0]  imm9s [4];
        logic [11:0] imm12s [4];
        imm9s[0] = 9'h000; imm9s[1] = 9'h0FF; imm9s[2] = 9'h100; imm9s[3] = 9'h1F8;
        imm12s[0] = 12'h000; imm12s[1] = 12'h001; imm12s[2] = 12'hFFF; imm12s[3] = 12'h123;

        repeat (4) @(negedge clk);
        chk(insn_ready === 1'b1 && !mem_req_valid && !rd_we && !wb_we && !sp_we
            && !done_o && !undef_o && !align_fault_o, "R11 reset state",
            {56'd0, insn_ready, mem_req_valid, rd_we, wb_we, sp_we, done_o, undef_o, align_fault_o},
            64'h80);
        rst = 1'b0;
        @(negedge clk);
        chk(insn_ready === 1'b1 && !mem_req_valid, "R11 idle after reset",
            {62'd0, insn_ready, mem_req_valid}, 64'd2);

        // sweep of forms, sizes, offsets and base sources
        for (int sz = 0; sz < 2; sz++)
            for (int m = 0; m < 3; m++)
                for (int k = 0; k < 4; k++)
                    for (int s = 0; s < 2; s++) begin
                        logic [11:0] imm;
                        logic [4:0]  rn;
                        imm = (m == 2) ? imm12s[k] : {3'd0, imm9s[k]};
                        rn  = (s != 0) ? 5'd31 : 5'(3 + k);
                        run_load(m, sz, imm, rn, 5'(7 + k),
                                 64'h0000_7FF0_0000_0000 + (64'(k) << 8), (k + sz) % 4, 0);
                    end

        // R7: misaligned stack pointer for every form
        for (int m = 0; m < 3; m++) begin
            run_load(m, 1, 12'h010, 5'd31, 5'd2, 64'h0000_7FF0_0000_0008, 0, 0);
            run_load(m, 0, 12'h010, 5'd31, 5'd2, 64'h0000_7FF0_0000_0001, 0, 0);
        end

        // R8: base equals destination on writeback forms
        for (int sz = 0; sz < 2; sz++)
            for (int m = 0; m < 2; m++)
                run_load(m, sz, 12'h1F0, 5'd5, 5'd5, 64'h0000_7FF0_0000_0000, 1, 0);
        // index 31 on both fields is not an overlap
        run_load(1, 1, 12'h010, 5'd31, 5'd31, 64'h0000_7FF0_0000_0100, 0, 0);
        run_load(2, 0, 12'h004, 5'd9, 5'd9, 64'h0000_7FF0_0000_0000, 2, 0);

        // R11: a word held valid while busy is not taken
        run_load(0, 1, 12'h008, 5'd4, 5'd6, 64'h0000_7FF0_0000_0000, 3, 1);
        @(negedge clk);
        chk(!undef_o && insn_ready, "R11 busy word ignored", {62'd0, undef_o, insn_ready}, 64'd1);

        // R1: illegal encodings
        good = enc(0, 1, 12'h010, 5'd3, 5'd4);
        run_bad(good & ~32'h8000_0000);
        run_bad(good & ~32'h1000_0000);
        run_bad(good |  32'h0400_0000);
        run_bad(good & ~32'h00C0_0000);
        run_bad(good |  32'h0080_0000);
        run_bad((good & ~32'h0300_0000) | 32'h0200_0000);
        run_bad(good |  32'h0300_0000);
        run_bad(good |  32'h0020_0000);
        run_bad(good & ~32'h0000_0C00);
        run_bad((good & ~32'h0000_0C00) | 32'h0000_0800);

        summary();
        $finish;
    end
endmodule